// File: doc/BRIEF.md
# Codec Control Register File

This block is the control-register bank of an audio codec. The serial link front end presents it with decoded register commands: a 7-bit even index, a 16-bit value, and a write or read strobe. The block stores the writable fields and enforces the reset values. It applies the special write rules: a soft reset on index 00h, read-only fields, masked bits, and indices that are ignored. It returns read data one cycle after a read request.

The stored state is decoded into control signals that go straight to the analog and conversion blocks. These cover effective attenuation and mute for the three output stages, beep level, mixer input gains, record source and gain, mode bits, powerdown controls, the variable-rate enable and the two converter sample rates. Ready flags and the codec identity straps are live inputs. They are sampled only when a read of their register is served.

Top module: `codec_ctrl_regfile`

## Requirements
- R1: The synchronous reset `rst`, or a write of any value to index 00h, returns every stored field to its default on the next clock edge. The defaults are: 02h/04h/06h = 8000h, 0Ah = 0000h, 0Ch/0Eh = 8008h, 10h..18h = 8808h, 1Ah = 0000h, 1Ch = 8000h, 20h = 0000h, 26h powerdown bits = 0, 2Ah = 0000h, 2Ch/32h = BB80h.
- R2: A read of index 00h returns 0D50h.
- R3: Output volume registers are 02h (master, stage 0), 04h (line level, stage 1) and 06h (mono, stage 2). Each has a 6-bit field per channel, left in D13:D8 and right in D5:D0, and a mute in D15. The decoded 5-bit attenuation equals field[4:0], or 31 (46.5 dB) when field bit 5 is set. All other bits read 0.
- R4: The beep register 0Ah holds a 4-bit attenuation in D4:D1 and a mute in D15. All other bits read 0.
- R5: Mixer input registers run from 0Ch to 18h: phone, mic, line, cd, video, aux, pcm, which are entries 0..6 of the packed mixer ports, 5 bits each. Each has a right gain in D4:D0 (01000 = 0 dB) and a mute in D15 that silences both channels. Stereo entries have a left gain in D12:D8. The mono entries 0Ch and 0Eh store no left field, and their left output mirrors the right. Bit D6 of 0Eh is the 20 dB mic boost.
- R6: Record select 1Ah holds the left source in D10:D8 and the right source in D2:D0. Record gain 1Ch holds the left gain in D11:D8, the right gain in D3:D0, and a mute in D15.
- R7: The general register 20h holds the post-3D PCM path in D15, 3D enable in D13, mono-out from mic in D9, mic 2 select in D8 and digital loopback in D7. Its other bits read 0. Writes to 22h have no effect, and 22h reads 0000h.
- R8: In register 26h, D14:D8 are writable powerdown controls. D7:D4 read 0 and D3:D0 read the live `ready_in` (D3 reference, D2 mixer, D1 DAC, D0 ADC). Writes to the low byte are ignored.
- R9: Register 28h is read-only and reads {id_strap[1:0], 13'b0, 1'b1}. Writes to it change nothing.
- R10: Bit D0 of 2Ah is the variable-rate enable, and its other bits read 0. 2Ch (DAC rate) and 32h (ADC rate) are full 16-bit registers.
- R11: A write to any other index, odd indices included, is ignored, and a read of such an index returns 0000h.
- R12: `rd_valid` is high exactly in the cycle after `rd_en`, with `rd_data` holding the value from before any write in the same cycle. `rd_data` keeps its value while no read is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr` |
| rd_en | input | 1 | Read strobe for `addr` |
| addr | input | 7 | Register index |
| wr_data | input | 16 | Write value |
| id_strap | input | 2 | Strapped codec identity bits |
| ready_in | input | 4 | Subsection ready flags |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| outvol_att_l | output | 15 | Left effective attenuation, 5 bits per output stage |
| outvol_att_r | output | 15 | Right effective attenuation, 5 bits per output stage |
| outvol_mute | output | 3 | Mute per output stage |
| beep_att | output | 4 | Beep attenuation |
| beep_mute | output | 1 | Beep mute |
| mix_gain_l | output | 35 | Left mixer gains, 5 bits per entry |
| mix_gain_r | output | 35 | Right mixer gains, 5 bits per entry |
| mix_mute | output | 7 | Mute per mixer entry |
| mic_boost | output | 1 | 20 dB mic boost |
| rec_src_l | output | 3 | Left record source |
| rec_src_r | output | 3 | Right record source |
| rec_gain_l | output | 4 | Left record gain |
| rec_gain_r | output | 4 | Right record gain |
| rec_mute | output | 1 | Record mute |
| pcm_post3d | output | 1 | PCM path after the 3D stage |
| en_3d | output | 1 | 3D enhancement on |
| mono_from_mic | output | 1 | Mono output takes the mic |
| mic2_sel | output | 1 | Mic 2 selected |
| loopback | output | 1 | Digital loopback |
| pwrdn | output | 7 | Powerdown controls |
| vra_en | output | 1 | Variable-rate enable |
| dac_rate | output | 16 | DAC sample rate |
| adc_rate | output | 16 | ADC sample rate |

## Verification
Every stored bit reaches a decoded output port, so a wrong write mask, default or soft-reset path shows on the decoded outputs in the cycle after the offending write. It also shows in `rd_data` one cycle after the next read of that index. Live fields (ready flags, straps) and the constant identity word exist only on the read path, so an error there appears only in the cycle after a read of 26h, 28h or 00h. The tests therefore read back every index class after writing all-ones to it, which exposes both leaking masked bits and missing writable bits.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

    localparam int DW        = 16;
    localparam int AW        = 7;
    localparam int NUM_OUT   = 3;
    localparam int NUM_MIX   = 7;
    localparam int NUM_MONO  = 2;
    localparam int NUM_SLOTS = 18;
    localparam int VOLW      = 5;
    localparam int SLW       = $clog2(NUM_SLOTS);

    localparam logic [AW-1:0] IDX_RESET = 7'h00;
    localparam logic [AW-1:0] IDX_3DDEP = 7'h22;
    localparam logic [AW-1:0] IDX_PWR   = 7'h26;
    localparam logic [AW-1:0] IDX_IDENT = 7'h28;

    localparam logic [DW-1:0] CAPS_WORD = 16'h0D50;

    // storage slot numbers
    localparam int S_OUT0 = 0;
    localparam int S_BEEP = 3;
    localparam int S_MIX0 = 4;
    localparam int S_RSEL = 11;
    localparam int S_RGAIN = 12;
    localparam int S_GP   = 13;
    localparam int S_PWR  = 14;
    localparam int S_EXT  = 15;
    localparam int S_DACR = 16;
    localparam int S_ADCR = 17;

    typedef enum logic [1:0] {
        K_VOLUME,
        K_MONO_MIX,
        K_STEREO_MIX,
        K_PLAIN
    } slot_kind_e;

    typedef struct packed {
        logic            valid;
        logic [SLW-1:0]  slot;
    } slot_hit_t;

    function automatic logic [AW-1:0] slot_addr(input int s);
        case (s)
            0:  return 7'h02;
            1:  return 7'h04;
            2:  return 7'h06;
            3:  return 7'h0A;
            4:  return 7'h0C;
            5:  return 7'h0E;
            6:  return 7'h10;
            7:  return 7'h12;
            8:  return 7'h14;
            9:  return 7'h16;
            10: return 7'h18;
            11: return 7'h1A;
            12: return 7'h1C;
            13: return 7'h20;
            14: return 7'h26;
            15: return 7'h2A;
            16: return 7'h2C;
            default: return 7'h32;
        endcase
    endfunction

    function automatic slot_kind_e slot_kind(input int s);
        if (s < S_BEEP)                  return K_VOLUME;
        if (s >= S_MIX0 && s < S_MIX0 + NUM_MONO) return K_MONO_MIX;
        if (s >= S_MIX0 + NUM_MONO && s < S_MIX0 + NUM_MIX) return K_STEREO_MIX;
        return K_PLAIN;
    endfunction

    function automatic logic [DW-1:0] slot_mask(input int s);
        case (slot_kind(s))
            K_VOLUME:     return 16'hBF3F;
            K_MONO_MIX:   return (s == S_MIX0 + 1) ? 16'h805F : 16'h801F;
            K_STEREO_MIX: return 16'h9F1F;
            default: begin
                case (s)
                    S_BEEP:  return 16'h801E;
                    S_RSEL:  return 16'h0707;
                    S_RGAIN: return 16'h8F0F;
                    S_GP:    return 16'hA380;
                    S_PWR:   return 16'h7F00;
                    S_EXT:   return 16'h0001;
                    default: return 16'hFFFF;
                endcase
            end
        endcase
    endfunction

    function automatic logic [DW-1:0] slot_default(input int s);
        case (slot_kind(s))
            K_VOLUME:     return 16'h8000;
            K_MONO_MIX:   return 16'h8008;
            K_STEREO_MIX: return 16'h8808;
            default: begin
                case (s)
                    S_RGAIN:        return 16'h8000;
                    S_DACR, S_ADCR: return 16'hBB80;
                    default:        return 16'h0000;
                endcase
            end
        endcase
    endfunction

    function automatic slot_hit_t find_slot(input logic [AW-1:0] a);
        slot_hit_t h;
        h.valid = 1'b0;
        h.slot  = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (a == slot_addr(s)) begin
                h.valid = 1'b1;
                h.slot  = SLW'(s);
            end
        end
        return h;
    endfunction

    // top bit of a 6-bit output field pins the level at full attenuation
    function automatic logic [VOLW-1:0] sat_volume(input logic [5:0] f);
        return f[5] ? {VOLW{1'b1}} : f[VOLW-1:0];
    endfunction

endpackage

// File: rtl/codec_reg_store.sv
module codec_reg_store
    import codec_regs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [DW-1:0]                 wr_data,
    output logic [NUM_SLOTS-1:0][DW-1:0]  regs
);

    logic soft_rst;
    assign soft_rst = wr_en && (addr == IDX_RESET);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [DW-1:0] MASK = slot_mask(s);
        localparam logic [DW-1:0] DEF  = slot_default(s);
        localparam logic [AW-1:0] IDX  = slot_addr(s);

        always_ff @(posedge clk) begin
            if (rst || soft_rst) begin
                regs[s] <= DEF;
            end else if (wr_en && addr == IDX) begin
                regs[s] <= wr_data & MASK;
            end
        end
    end

endmodule

// File: rtl/codec_read_port.sv
module codec_read_port
    import codec_regs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_en,
    input  logic [AW-1:0]                 addr,
    input  logic [NUM_SLOTS-1:0][DW-1:0]  regs,
    input  logic [1:0]                    id_strap,
    input  logic [3:0]                    ready_in,
    output logic                          rd_valid,
    output logic [DW-1:0]                 rd_data
);

    slot_hit_t       hit;
    logic [DW-1:0]   rd_word;

    always_comb begin
        hit = find_slot(addr);
        if (addr == IDX_RESET) begin
            rd_word = CAPS_WORD;
        end else if (addr == IDX_IDENT) begin
            rd_word = {id_strap, 13'b0, 1'b1};
        end else if (addr == IDX_PWR) begin
            rd_word = {regs[S_PWR][15:8], 4'b0, ready_in};
        end else if (hit.valid) begin
            rd_word = regs[hit.slot];
        end else begin
            rd_word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_word;
        end
    end

endmodule

// File: rtl/codec_ctrl_decode.sv
module codec_ctrl_decode
    import codec_regs_pkg::*;
(
    input  logic [NUM_SLOTS-1:0][DW-1:0] regs,
    output logic [NUM_OUT*VOLW-1:0]      outvol_att_l,
    output logic [NUM_OUT*VOLW-1:0]      outvol_att_r,
    output logic [NUM_OUT-1:0]           outvol_mute,
    output logic [3:0]                   beep_att,
    output logic                         beep_mute,
    output logic [NUM_MIX*VOLW-1:0]      mix_gain_l,
    output logic [NUM_MIX*VOLW-1:0]      mix_gain_r,
    output logic [NUM_MIX-1:0]           mix_mute,
    output logic                         mic_boost,
    output logic [2:0]                   rec_src_l,
    output logic [2:0]                   rec_src_r,
    output logic [3:0]                   rec_gain_l,
    output logic [3:0]                   rec_gain_r,
    output logic                         rec_mute,
    output logic                         pcm_post3d,
    output logic                         en_3d,
    output logic                         mono_from_mic,
    output logic                         mic2_sel,
    output logic                         loopback,
    output logic [6:0]                   pwrdn,
    output logic                         vra_en,
    output logic [DW-1:0]                dac_rate,
    output logic [DW-1:0]                adc_rate
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assign outvol_att_l[o*VOLW +: VOLW] = sat_volume(regs[S_OUT0+o][13:8]);
        assign outvol_att_r[o*VOLW +: VOLW] = sat_volume(regs[S_OUT0+o][5:0]);
        assign outvol_mute[o]               = regs[S_OUT0+o][15];
    end

    for (genvar k = 0; k < NUM_MIX; k++) begin : g_mix
        assign mix_gain_r[k*VOLW +: VOLW] = regs[S_MIX0+k][VOLW-1:0];
        if (k < NUM_MONO) begin : g_mono
            assign mix_gain_l[k*VOLW +: VOLW] = regs[S_MIX0+k][VOLW-1:0];
        end else begin : g_stereo
            assign mix_gain_l[k*VOLW +: VOLW] = regs[S_MIX0+k][8 +: VOLW];
        end
        assign mix_mute[k] = regs[S_MIX0+k][15];
    end

    assign beep_att      = regs[S_BEEP][4:1];
    assign beep_mute     = regs[S_BEEP][15];
    assign mic_boost     = regs[S_MIX0+1][6];
    assign rec_src_l     = regs[S_RSEL][10:8];
    assign rec_src_r     = regs[S_RSEL][2:0];
    assign rec_gain_l    = regs[S_RGAIN][11:8];
    assign rec_gain_r    = regs[S_RGAIN][3:0];
    assign rec_mute      = regs[S_RGAIN][15];
    assign pcm_post3d    = regs[S_GP][15];
    assign en_3d         = regs[S_GP][13];
    assign mono_from_mic = regs[S_GP][9];
    assign mic2_sel      = regs[S_GP][8];
    assign loopback      = regs[S_GP][7];
    assign pwrdn         = regs[S_PWR][14:8];
    assign vra_en        = regs[S_EXT][0];
    assign dac_rate      = regs[S_DACR];
    assign adc_rate      = regs[S_ADCR];

endmodule

// File: rtl/codec_ctrl_regfile.sv
module codec_ctrl_regfile
    import codec_regs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [1:0]               id_strap,
    input  logic [3:0]               ready_in,
    output logic                     rd_valid,
    output logic [DW-1:0]            rd_data,
    output logic [NUM_OUT*VOLW-1:0]  outvol_att_l,
    output logic [NUM_OUT*VOLW-1:0]  outvol_att_r,
    output logic [NUM_OUT-1:0]       outvol_mute,
    output logic [3:0]               beep_att,
    output logic                     beep_mute,
    output logic [NUM_MIX*VOLW-1:0]  mix_gain_l,
    output logic [NUM_MIX*VOLW-1:0]  mix_gain_r,
    output logic [NUM_MIX-1:0]       mix_mute,
    output logic                     mic_boost,
    output logic [2:0]               rec_src_l,
    output logic [2:0]               rec_src_r,
    output logic [3:0]               rec_gain_l,
    output logic [3:0]               rec_gain_r,
    output logic                     rec_mute,
    output logic                     pcm_post3d,
    output logic                     en_3d,
    output logic                     mono_from_mic,
    output logic                     mic2_sel,
    output logic                     loopback,
    output logic [6:0]               pwrdn,
    output logic                     vra_en,
    output logic [DW-1:0]            dac_rate,
    output logic [DW-1:0]            adc_rate
);

    logic [NUM_SLOTS-1:0][DW-1:0] regs;

    codec_reg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    codec_read_port u_read (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (addr),
        .regs     (regs),
        .id_strap (id_strap),
        .ready_in (ready_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    codec_ctrl_decode u_dec (
        .regs          (regs),
        .outvol_att_l  (outvol_att_l),
        .outvol_att_r  (outvol_att_r),
        .outvol_mute   (outvol_mute),
        .beep_att      (beep_att),
        .beep_mute     (beep_mute),
        .mix_gain_l    (mix_gain_l),
        .mix_gain_r    (mix_gain_r),
        .mix_mute      (mix_mute),
        .mic_boost     (mic_boost),
        .rec_src_l     (rec_src_l),
        .rec_src_r     (rec_src_r),
        .rec_gain_l    (rec_gain_l),
        .rec_gain_r    (rec_gain_r),
        .rec_mute      (rec_mute),
        .pcm_post3d    (pcm_post3d),
        .en_3d         (en_3d),
        .mono_from_mic (mono_from_mic),
        .mic2_sel      (mic2_sel),
        .loopback      (loopback),
        .pwrdn         (pwrdn),
        .vra_en        (vra_en),
        .dac_rate      (dac_rate),
        .adc_rate      (adc_rate)
    );

endmodule

// File: rtl/codec_ctrl_regfile_chk.sv
module codec_ctrl_regfile_chk
    import codec_regs_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [AW-1:0]            addr,
    input logic [DW-1:0]            wr_data,
    input logic [1:0]               id_strap,
    input logic [3:0]               ready_in,
    input logic                     rd_valid,
    input logic [DW-1:0]            rd_data,
    input logic [NUM_OUT*VOLW-1:0]  outvol_att_l,
    input logic [NUM_OUT*VOLW-1:0]  outvol_att_r,
    input logic [NUM_OUT-1:0]       outvol_mute,
    input logic                     rec_mute,
    input logic [6:0]               pwrdn,
    input logic [DW-1:0]            dac_rate,
    input logic [DW-1:0]            adc_rate
);

    a_r1_soft_reset: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == IDX_RESET) |=>
        (dac_rate == 16'hBB80 && adc_rate == 16'hBB80 && rec_mute
         && outvol_mute == '1 && pwrdn == '0));

    a_r2_caps_word: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == IDX_RESET) |=> (rd_data == 16'h0D50));

    a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 7'h02 && wr_data[5]) |=> (outvol_att_r[VOLW-1:0] == 5'd31));

    a_r7_ignore_22: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == IDX_3DDEP) |=>
        ($stable(outvol_att_l) && $stable(outvol_att_r) && $stable(pwrdn) && $stable(dac_rate)));

    a_r8_ready_live: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == IDX_PWR) |=> (rd_data[7:0] == {4'b0, $past(ready_in)}));

    a_r9_ident: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == IDX_IDENT) |=> (rd_data == {$past(id_strap), 13'b0, 1'b1}));

    a_r11_odd_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[0]) |=> (rd_data == '0));

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r12_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    a_r12_hold_data: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

bind codec_ctrl_regfile codec_ctrl_regfile_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .id_strap     (id_strap),
    .ready_in     (ready_in),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .outvol_att_l (outvol_att_l),
    .outvol_att_r (outvol_att_r),
    .outvol_mute  (outvol_mute),
    .rec_mute     (rec_mute),
    .pwrdn        (pwrdn),
    .dac_rate     (dac_rate),
    .adc_rate     (adc_rate)
);

// File: tb/tb_codec_ctrl_regfile.sv
`timescale 1ns/1ps
module tb_codec_ctrl_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [6:0]  addr;
    logic [15:0] wr_data;
    logic [1:0]  id_strap;
    logic [3:0]  ready_in;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [14:0] outvol_att_l, outvol_att_r;
    logic [2:0]  outvol_mute;
    logic [3:0]  beep_att;
    logic        beep_mute;
    logic [34:0] mix_gain_l, mix_gain_r;
    logic [6:0]  mix_mute;
    logic        mic_boost;
    logic [2:0]  rec_src_l, rec_src_r;
    logic [3:0]  rec_gain_l, rec_gain_r;
    logic        rec_mute, pcm_post3d, en_3d, mono_from_mic, mic2_sel, loopback;
    logic [6:0]  pwrdn;
    logic        vra_en;
    logic [15:0] dac_rate, adc_rate;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    codec_ctrl_regfile dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        chk("R12 rd_valid", rd_valid, 1'b1);
    endtask

    task automatic t_reset_defaults();
        rd(7'h02, rv); chk("R1 default 02h", rv, 16'h8000);
        rd(7'h0E, rv); chk("R1 default 0Eh", rv, 16'h8008);
        rd(7'h12, rv); chk("R1 default 12h", rv, 16'h8808);
        rd(7'h1C, rv); chk("R1 default 1Ch", rv, 16'h8000);
        rd(7'h2C, rv); chk("R1 default 2Ch", rv, 16'hBB80);
        chk("R1 default outputs", {outvol_mute, mix_mute, beep_mute, rec_mute, pwrdn},
            {3'b111, 7'h7F, 1'b0, 1'b1, 7'h00});
        chk("R1 default mix gains", {mix_gain_l[14:10], mix_gain_r[4:0]}, {5'd8, 5'd8});
        rd(7'h00, rv); chk("R2 caps word", rv, 16'h0D50);
    endtask

    task automatic t_outvol();
        wr(7'h02, 16'h2005);
        chk("R3 saturated left", outvol_att_l[4:0], 5'd31);
        chk("R3 plain right", outvol_att_r[4:0], 5'd5);
        chk("R3 unmuted", outvol_mute[0], 1'b0);
        wr(7'h06, 16'hDF1E);
        rd(7'h06, rv); chk("R3 mask 06h", rv, 16'h9F1E);
        chk("R3 stage 2 decode", {outvol_mute[2], outvol_att_l[14:10], outvol_att_r[14:10]},
            {1'b1, 5'd31, 5'd30});
    endtask

    task automatic t_beep();
        wr(7'h0A, 16'hFFFF);
        rd(7'h0A, rv); chk("R4 mask 0Ah", rv, 16'h801E);
        chk("R4 decode", {beep_mute, beep_att}, {1'b1, 4'hF});
    endtask

    task automatic t_mixer();
        wr(7'h10, 16'h0A15);
        chk("R5 line gains", {mix_mute[2], mix_gain_l[14:10], mix_gain_r[14:10]},
            {1'b0, 5'h0A, 5'h15});
        wr(7'h0C, 16'h1F13);
        rd(7'h0C, rv); chk("R5 mono mask", rv, 16'h0013);
        chk("R5 mono mirror", mix_gain_l[4:0], 5'h13);
        wr(7'h0E, 16'hFFFF);
        rd(7'h0E, rv); chk("R5 mic mask", rv, 16'h805F);
        chk("R5 boost and mute", {mic_boost, mix_mute[1]}, 2'b11);
    endtask

    task automatic t_record();
        wr(7'h1A, 16'hFFFF);
        rd(7'h1A, rv); chk("R6 select mask", rv, 16'h0707);
        wr(7'h1A, 16'h0305);
        chk("R6 sources", {rec_src_l, rec_src_r}, {3'd3, 3'd5});
        wr(7'h1C, 16'h0A05);
        chk("R6 gains", {rec_mute, rec_gain_l, rec_gain_r}, {1'b0, 4'hA, 4'h5});
    endtask

    task automatic t_general();
        wr(7'h20, 16'hFFFF);
        rd(7'h20, rv); chk("R7 general mask", rv, 16'hA380);
        chk("R7 mode bits", {pcm_post3d, en_3d, mono_from_mic, mic2_sel, loopback}, 5'b11111);
        wr(7'h22, 16'hFFFF);
        rd(7'h22, rv); chk("R7 22h reads zero", rv, 16'h0000);
        rd(7'h20, rv); chk("R7 20h untouched by 22h", rv, 16'hA380);
    endtask

    task automatic t_power();
        ready_in = 4'b1010;
        wr(7'h26, 16'hFFFF);
        rd(7'h26, rv); chk("R8 power read", rv, 16'h7F0A);
        chk("R8 pwrdn out", pwrdn, 7'h7F);
        ready_in = 4'b0101;
        rd(7'h26, rv); chk("R8 live ready", rv, 16'h7F05);
    endtask

    task automatic t_ident();
        id_strap = 2'b10;
        rd(7'h28, rv); chk("R9 ident", rv, 16'h8001);
        wr(7'h28, 16'h0000);
        rd(7'h28, rv); chk("R9 ident write ignored", rv, 16'h8001);
        id_strap = 2'b01;
        rd(7'h28, rv); chk("R9 strap follow", rv, 16'h4001);
    endtask

    task automatic t_rates();
        wr(7'h2C, 16'h3E80);
        wr(7'h32, 16'hAC44);
        wr(7'h2A, 16'hFFFF);
        rd(7'h2A, rv); chk("R10 ext mask", rv, 16'h0001);
        chk("R10 rates", {vra_en, dac_rate, adc_rate}, {1'b1, 16'h3E80, 16'hAC44});
    endtask

    task automatic t_reserved();
        wr(7'h7C, 16'h1234);
        wr(7'h03, 16'hFFFF);
        rd(7'h7C, rv); chk("R11 reserved read", rv, 16'h0000);
        rd(7'h03, rv); chk("R11 odd read", rv, 16'h0000);
        chk("R11 no side effect", {dac_rate, pwrdn}, {16'h3E80, 7'h7F});
    endtask

    task automatic t_soft_reset();
        wr(7'h00, 16'h1234);
        chk("R1 soft reset outputs", {dac_rate, adc_rate, rec_mute, pwrdn, vra_en, en_3d},
            {16'hBB80, 16'hBB80, 1'b1, 7'h00, 1'b0, 1'b0});
        rd(7'h0A, rv); chk("R1 soft reset 0Ah", rv, 16'h0000);
        rd(7'h10, rv); chk("R1 soft reset 10h", rv, 16'h8808);
    endtask

    task automatic t_read_timing();
        wr(7'h2C, 16'h1111);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 7'h2C; wr_data = 16'h2222;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R12 old value on same-cycle write", rd_data, 16'h1111);
        @(negedge clk);
        chk("R12 valid drops", rd_valid, 1'b0);
        chk("R12 data held", rd_data, 16'h1111);
        rd(7'h2C, rv); chk("R12 new value later", rv, 16'h2222);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
        id_strap = 2'b00; ready_in = 4'b0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R12 reset rd_valid", rd_valid, 1'b0);
        t_reset_defaults();
        t_outvol();
        t_beep();
        t_mixer();
        t_record();
        t_general();
        t_power();
        t_ident();
        t_rates();
        t_reserved();
        t_soft_reset();
        t_read_timing();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule